// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Interrupt Routing

This block receives asynchronous serial frames on a single RX line. It uses a per-clock baud tick from an external rate generator and takes `OVERSAMPLE` ticks per bit. The line first passes through a flip-flop synchronizer. The block then waits for a falling start bit and confirms it at half a bit time. After that it shifts in `DATA_BITS` data bits, least significant bit first, then an optional even or odd parity bit, then one stop bit. When the stop bit is sampled, the assembled word moves into a holding register and one interrupt pulse goes out.

Reception runs only while both the unit enable and the receive enable are high. Dropping either enable in the middle of a frame abandons the frame. When that happens the holding register, the buffer-full flag and the error flags keep their values, and no interrupt is raised. Parity and framing errors do not stop a frame. The block always finishes the frame through the stop bit before it reports the error.

Overrun means a frame completes while the previous word is still unread. In that case the holding register keeps the old word. A routing input chooses where errored frames are reported: on the normal completion pulse, or on a separate error pulse.

Top module: `serial_rx_unit`

## Requirements
- R1: Reception is active only while `unit_en` and `rx_en` are both 1. While either is 0, the frame logic stays idle and neither `irq_done` nor `irq_err` pulses.
- R2: While reception is inactive, `rx_data` keeps its value and no error flag is set by activity on the RX line.
- R3: A frame starts only when the synchronized line is low on a baud tick while the receiver is idle. The start is confirmed `OVERSAMPLE/2` ticks later. If the line is high at that point, the receiver goes back to idle and gives no pulse. With 16 ticks per bit and a tick every clock, a low pulse of 8 clocks or fewer is rejected.
- R4: Each later bit is sampled `OVERSAMPLE` ticks after the previous one. The bits, in order, are `DATA_BITS` data bits, then one parity bit when `par_en`=1, then one stop bit. The first data bit lands in `rx_data[0]`.
- R5: With `par_odd`=0, the parity check passes when the count of 1s over the data and parity bits is even. With `par_odd`=1 it passes when that count is odd. A mismatch sets `err_parity`.
- R6: A stop bit sampled low sets `err_frame`. A frame with a parity or framing error still runs to its stop bit and still loads its data into `rx_data`.
- R7: On the stop-bit sample, the holding register loads (unless R8 applies) on the same edge that exactly one single-cycle pulse is raised. That pulse is `irq_err` when `err_route`=1 and the frame has a parity, framing or overrun error. Otherwise it is `irq_done`.
- R8: A frame that completes while `buf_full`=1, with no `buf_rd` in that cycle, leaves `rx_data` unchanged, sets `err_overrun` and keeps `buf_full` at 1.
- R9: `buf_full` resets to 0, is set when the holding register loads, and is cleared by a `buf_rd` pulse. If both happen in the same cycle, the load wins. `rx_data` resets to 0.
- R10: The error flags reset to 0. Once set, each flag stays set until a `stat_rd` pulse. If a set and a clear happen in the same cycle, the set wins.
- R11: Clearing `rx_en` (or `unit_en`) during a frame abandons it. No pulse follows, `rx_data`, `buf_full` and the flags stay unchanged, and a frame sent after re-enabling is received normally.
- R12: With a tick every clock, let edge 0 be the first rising clock edge that sees the RX pin low. Outputs update at edge `SYNC_STAGES + OVERSAMPLE/2 + OVERSAMPLE*(DATA_BITS+p+1)`, where p is 1 with parity and 0 without. With the default parameters that is edge 154 without parity and edge 170 with parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Global unit enable |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| err_route | input | 1 | 1 = errored frames pulse `irq_err`; 0 = they pulse `irq_done` |
| baud_tick | input | 1 | Oversampling tick from the rate generator |
| rx_pin | input | 1 | Asynchronous serial line, idle high |
| buf_rd | input | 1 | Read strobe that clears `buf_full` |
| stat_rd | input | 1 | Read strobe that clears the error flags |
| rx_data | output | DATA_BITS (8) | Holding register |
| buf_full | output | 1 | Holding register has unread data |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_overrun | output | 1 | Sticky overrun flag |
| irq_done | output | 1 | Completion pulse |
| irq_err | output | 1 | Error pulse |

## Verification
The bench holds the tick high, so every result has a fixed clock edge: the stop-bit sample falls at edge 154, or 170 with parity, counted from the first edge that sees the start bit. The bench counts falling edges from the moment it drives the start bit. It checks that both pulses are still low at the falling edge just before that rising edge. At the falling edge just after it, it checks the pulse, the data and the flags, and one edge later it checks that the pulse has gone. For glitch, disable and abort stimuli, the bench waits well past the edge at which a frame would have finished. It then compares its running pulse counts and the holding state with their values before the stimulus.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic parity;
      logic framing;
      logic overrun;
   } rx_err_t;

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("serrx_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RESET_VAL;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], din};
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/serrx_framer.sv
module serrx_framer
   import serrx_pkg::*;
#(
   parameter int DATA_BITS  = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic                 tick,
   input  logic                 rx_s,
   input  logic                 par_en,
   input  logic                 par_odd,
   output logic                 done,
   output logic [DATA_BITS-1:0] data,
   output logic                 perr,
   output logic                 ferr
);

   localparam int CW = $clog2(OVERSAMPLE);
   localparam int BW = $clog2(DATA_BITS);
   localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

   rx_state_e            st;
   logic [CW-1:0]        cnt;
   logic [BW-1:0]        bidx;
   logic [DATA_BITS-1:0] shreg;
   logic                 perr_q;
   logic                 bit_end;

   assign bit_end = tick && (cnt == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         shreg  <= '0;
         perr_q <= 1'b0;
      end else if (!active) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         perr_q <= 1'b0;
      end else if (tick) begin
         unique case (st)
            ST_IDLE: begin
               if (!rx_s) begin
                  st  <= ST_START;
                  cnt <= '0;
               end
            end
            ST_START: begin
               if (cnt == MID_CNT) begin
                  cnt    <= '0;
                  bidx   <= '0;
                  perr_q <= 1'b0;
                  st     <= rx_s ? ST_IDLE : ST_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == LAST_CNT) begin
                  cnt   <= '0;
                  shreg <= {rx_s, shreg[DATA_BITS-1:1]};
                  if (bidx == LAST_BIT) st <= par_en ? ST_PAR : ST_STOP;
                  else                  bidx <= bidx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (cnt == LAST_CNT) begin
                  cnt    <= '0;
                  perr_q <= (^shreg) ^ rx_s ^ par_odd;
                  st     <= ST_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (cnt == LAST_CNT) begin
                  cnt <= '0;
                  st  <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done = active && bit_end && (st == ST_STOP);
   assign data = shreg;
   assign perr = perr_q;
   assign ferr = !rx_s;

   // R3: an idle receiver with no low line on a tick stays idle
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !(tick && !rx_s)) |=> (st == ST_IDLE));

   // R11: losing the enable returns the framer to idle on the next edge
   a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (st == ST_IDLE));

   // R4: the bit counter never runs past its last position
   a_r4_bidx_range: assert property (@(posedge clk) disable iff (!rst_n)
      bidx <= LAST_BIT);

endmodule

// File: rtl/serrx_report.sv
module serrx_report
   import serrx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done,
   input  logic [DATA_BITS-1:0] data,
   input  logic                 perr,
   input  logic                 ferr,
   input  logic                 err_route,
   input  logic                 buf_rd,
   input  logic                 stat_rd,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 buf_full,
   output rx_err_t              errs,
   output logic                 irq_done,
   output logic                 irq_err
);

   logic ovr_now;
   logic any_err;

   assign ovr_now = done && buf_full && !buf_rd;
   assign any_err = perr || ferr || ovr_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         buf_full <= 1'b0;
         errs     <= '0;
         irq_done <= 1'b0;
         irq_err  <= 1'b0;
      end else begin
         irq_done <= 1'b0;
         irq_err  <= 1'b0;
         if (buf_rd)  buf_full <= 1'b0;
         if (stat_rd) errs     <= '0;
         if (done) begin
            if (!ovr_now) begin
               rx_data  <= data;
               buf_full <= 1'b1;
            end
            if (perr)    errs.parity  <= 1'b1;
            if (ferr)    errs.framing <= 1'b1;
            if (ovr_now) errs.overrun <= 1'b1;
            if (any_err && err_route) irq_err  <= 1'b1;
            else                      irq_done <= 1'b1;
         end
      end
   end

   // R7: the holding register only changes together with a pulse
   a_r7_load_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> (irq_done || irq_err));

   // R7: never both pulses together
   a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_done, irq_err}));

   // R7: the error pulse only follows error routing
   a_r7_route: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> $past(err_route));

   // R7: pulses last a single cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done);
   a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |=> !irq_err);

   // R8: an overrun leaves the holding register alone
   a_r8_keep_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(errs.overrun) |-> $stable(rx_data));

   // R9: full stays set until a read strobe
   a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && !buf_rd) |=> buf_full);

   // R10: flags are sticky until a status read
   a_r10_sticky_par: assert property (@(posedge clk) disable iff (!rst_n)
      (errs.parity && !stat_rd) |=> errs.parity);
   a_r10_sticky_frm: assert property (@(posedge clk) disable iff (!rst_n)
      (errs.framing && !stat_rd) |=> errs.framing);
   a_r10_sticky_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (errs.overrun && !stat_rd) |=> errs.overrun);

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
   import serrx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 unit_en,
   input  logic                 rx_en,
   input  logic                 par_en,
   input  logic                 par_odd,
   input  logic                 err_route,
   input  logic                 baud_tick,
   input  logic                 rx_pin,
   input  logic                 buf_rd,
   input  logic                 stat_rd,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 buf_full,
   output logic                 err_parity,
   output logic                 err_frame,
   output logic                 err_overrun,
   output logic                 irq_done,
   output logic                 irq_err
);

   generate
      if (DATA_BITS < 2) begin : g_bad_data
         $error("serial_rx_unit: DATA_BITS must be at least 2");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_ovs
         $error("serial_rx_unit: OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("serial_rx_unit: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic                 active;
   logic                 rx_s;
   logic                 f_done;
   logic [DATA_BITS-1:0] f_data;
   logic                 f_perr;
   logic                 f_ferr;
   rx_err_t              errs;

   assign active = unit_en && rx_en;

   serrx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_pin),
      .dout (rx_s)
   );

   serrx_framer #(
      .DATA_BITS (DATA_BITS),
      .OVERSAMPLE(OVERSAMPLE)
   ) u_framer (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .tick   (baud_tick),
      .rx_s   (rx_s),
      .par_en (par_en),
      .par_odd(par_odd),
      .done   (f_done),
      .data   (f_data),
      .perr   (f_perr),
      .ferr   (f_ferr)
   );

   serrx_report #(
      .DATA_BITS(DATA_BITS)
   ) u_report (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (f_done),
      .data     (f_data),
      .perr     (f_perr),
      .ferr     (f_ferr),
      .err_route(err_route),
      .buf_rd   (buf_rd),
      .stat_rd  (stat_rd),
      .rx_data  (rx_data),
      .buf_full (buf_full),
      .errs     (errs),
      .irq_done (irq_done),
      .irq_err  (irq_err)
   );

   assign err_parity  = errs.parity;
   assign err_frame   = errs.framing;
   assign err_overrun = errs.overrun;

   // R1: no pulse follows a cycle with reception inactive
   a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!irq_done && !irq_err));

   // R2: holding register frozen while inactive
   a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(rx_data));

   // R2: no flag rises while inactive
   a_r2_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!$rose(err_parity) && !$rose(err_frame) && !$rose(err_overrun)));

endmodule

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DBITS      = 8;
   localparam int OVS        = 16;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             unit_en, rx_en, par_en, par_odd, err_route;
   logic             baud_tick, rx_pin, buf_rd, stat_rd;
   logic [DBITS-1:0] rx_data;
   logic             buf_full, err_parity, err_frame, err_overrun;
   logic             irq_done, irq_err;

   int n_cmp = 0;
   int n_bad = 0;
   int n_done_seen = 0;
   int n_err_seen  = 0;
   bit finished = 0;

   // model of the visible state
   logic [DBITS-1:0] m_data;
   bit m_full, m_pe, m_fe, m_ov;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_rx_unit #(
      .DATA_BITS(DBITS), .OVERSAMPLE(OVS), .SYNC_STAGES(2)
   ) u_serial_rx_unit (
      .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .rx_en(rx_en),
      .par_en(par_en), .par_odd(par_odd), .err_route(err_route),
      .baud_tick(baud_tick), .rx_pin(rx_pin), .buf_rd(buf_rd), .stat_rd(stat_rd),
      .rx_data(rx_data), .buf_full(buf_full), .err_parity(err_parity),
      .err_frame(err_frame), .err_overrun(err_overrun),
      .irq_done(irq_done), .irq_err(irq_err)
   );

   always @(negedge clk) begin
      if (irq_done) n_done_seen++;
      if (irq_err)  n_err_seen++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_state(input string tag);
      chk({tag, " rx_data"},  rx_data,     m_data);
      chk({tag, " buf_full"}, buf_full,    m_full);
      chk({tag, " parity"},   err_parity,  m_pe);
      chk({tag, " frame"},    err_frame,   m_fe);
      chk({tag, " overrun"},  err_overrun, m_ov);
   endtask

   task automatic gap(input int n);
      rx_pin = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read();
      @(negedge clk); buf_rd = 1'b1;
      @(negedge clk); buf_rd = 1'b0;
      m_full = 0;
   endtask

   task automatic do_stat();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
      m_pe = 0; m_fe = 0; m_ov = 0;
   endtask

   // drives a frame and returns at the falling edge just before the stop sample edge
   task automatic send_frame(input logic [DBITS-1:0] d, input bit with_par,
                             input bit par_val, input bit stop_val);
      @(negedge clk);
      rx_pin = 1'b0;
      repeat (OVS) @(negedge clk);
      for (int i = 0; i < DBITS; i++) begin
         rx_pin = d[i];
         repeat (OVS) @(negedge clk);
      end
      if (with_par) begin
         rx_pin = par_val;
         repeat (OVS) @(negedge clk);
      end
      rx_pin = stop_val;
      repeat (2 + OVS/2) @(negedge clk);
      chk("R12 no early done", irq_done, 1'b0);
      chk("R12 no early err",  irq_err,  1'b0);
   endtask

   task automatic rx_and_check(input string tag, input logic [DBITS-1:0] d,
                               input bit with_par, input bit par_val, input bit stop_val);
      bit pe, fe, ov, anyerr;
      pe = with_par && ((^d) ^ par_val ^ par_odd);
      fe = !stop_val;
      ov = m_full;
      anyerr = pe || fe || ov;
      send_frame(d, with_par, par_val, stop_val);
      @(negedge clk);
      if (!ov) begin m_data = d; m_full = 1; end
      if (pe) m_pe = 1;
      if (fe) m_fe = 1;
      if (ov) m_ov = 1;
      chk({tag, " R7 irq_done"}, irq_done, !(anyerr && err_route));
      chk({tag, " R7 irq_err"},  irq_err,  anyerr && err_route);
      chk_state(tag);
      @(negedge clk);
      chk({tag, " R7 pulse ends"}, {irq_done, irq_err}, 2'b00);
      gap(24);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int dc, ec;
      rst_n = 1'b0; unit_en = 0; rx_en = 0; par_en = 0; par_odd = 0;
      err_route = 0; baud_tick = 1; rx_pin = 1; buf_rd = 0; stat_rd = 0;
      m_data = '0; m_full = 0; m_pe = 0; m_fe = 0; m_ov = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 R10: reset state
      chk_state("R9 R10 reset");
      chk("R7 reset pulses", {irq_done, irq_err}, 2'b00);

      unit_en = 1; @(negedge clk); rx_en = 1;
      gap(4);

      // R4 R12: every byte, no parity
      for (int v = 0; v < 256; v++) begin
         rx_and_check("R4 sweep", v[7:0], 0, 0, 1);
         do_read();
      end

      // R5: even and odd parity, correct parity bit
      par_en = 1; par_odd = 0;
      for (int v = 0; v < 256; v += 4) begin
         rx_and_check("R5 even", v[7:0], 1, ^v[7:0], 1);
         do_read();
      end
      par_odd = 1;
      for (int v = 1; v < 256; v += 4) begin
         rx_and_check("R5 odd", v[7:0], 1, ~^v[7:0], 1);
         do_read();
      end

      // R5 R7: wrong parity under both routings
      par_odd = 0; err_route = 0;
      rx_and_check("R5 bad par route0", 8'hA5, 1, 1, 1);
      do_read();
      err_route = 1;
      rx_and_check("R5 bad par route1", 8'h3B, 1, 0, 1);
      do_read();
      do_stat();
      @(negedge clk);
      chk_state("R10 cleared");

      // R6: framing errors still load data
      par_en = 0;
      rx_and_check("R6 frame route1", 8'h3C, 0, 0, 0);
      do_read();
      err_route = 0;
      rx_and_check("R6 frame route0", 8'hC3, 0, 0, 0);
      do_read();
      // R10: flag survives a clean frame
      rx_and_check("R10 sticky", 8'h5A, 0, 0, 1);
      do_read();
      do_stat();

      // R8: overrun keeps old word
      rx_and_check("R8 first", 8'h11, 0, 0, 1);
      rx_and_check("R8 ovr route0", 8'h22, 0, 0, 1);
      err_route = 1;
      rx_and_check("R8 ovr route1", 8'h33, 0, 0, 1);
      do_read();
      @(negedge clk);
      chk_state("R9 read clears full");
      do_stat();

      // R3: short low pulses are rejected
      dc = n_done_seen; ec = n_err_seen;
      @(negedge clk); rx_pin = 0; repeat (5) @(negedge clk); gap(200);
      @(negedge clk); rx_pin = 0; repeat (8) @(negedge clk); gap(200);
      chk("R3 glitch no done", n_done_seen, dc);
      chk("R3 glitch no err",  n_err_seen,  ec);
      chk_state("R3 glitch state");
      err_route = 0;
      rx_and_check("R3 after glitch", 8'h77, 0, 0, 1);

      // R1 R2: frames while disabled (buffer still full, so a frame would overrun)
      dc = n_done_seen; ec = n_err_seen;
      rx_en = 0;
      send_frame(8'h5A, 0, 0, 1); gap(24);
      rx_en = 1; unit_en = 0;
      send_frame(8'hA5, 0, 0, 0); gap(24);
      unit_en = 1;
      chk("R1 off no done", n_done_seen, dc);
      chk("R1 off no err",  n_err_seen,  ec);
      chk_state("R2 off state");
      gap(4);

      // R11: abort mid-frame
      @(negedge clk); rx_pin = 0;
      repeat (OVS) @(negedge clk);
      for (int i = 0; i < DBITS; i++) begin
         rx_pin = i[0];
         if (i == 4) rx_en = 0;
         repeat (OVS) @(negedge clk);
      end
      rx_pin = 0; repeat (OVS) @(negedge clk);
      gap(24);
      chk("R11 abort no done", n_done_seen, dc);
      chk("R11 abort no err",  n_err_seen,  ec);
      chk_state("R11 abort state");
      rx_en = 1;
      gap(4);
      do_read();
      rx_and_check("R11 after abort", 8'h96, 0, 0, 1);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule